// File: doc/BRIEF.md
# Clock Mode and PLL Controller

This block chooses the clock that feeds a small processor core. A static oscillator-mode code tells it which oscillator family is fitted, whether the times-4 PLL may be used, and how the second oscillator pin is used. That pin can carry the feedback path of a crystal, carry the oscillator frequency divided by four, or serve as an ordinary port pin. The PLL itself is analog and lies outside the block. Here it appears only as an enable output and a ready input.

The PLL is engaged under one of two policies, and the mode code picks which one applies. Under the software policy, a control bit that every reset clears starts the PLL at run time. Under the configuration policy, the PLL state is latched from the mode code. It is re-read only at power-on reset or while the core runs from the secondary oscillator, so that a round trip through the secondary source is the only way to change it during operation. A lock down-counter holds the core after reset, after a wake event and after each PLL start. A change of clock select is committed only once that counter has expired, so the core never runs across a switch.

Top module: `clk_pll_ctrl`

## Requirements
- R1: The pin control `pin_mux_o` follows `mode_i`. Codes 4 and 7 give 1 (divided-by-4 clock out), codes 5 and 9 give 2 (general purpose I/O), and every other code gives 0 (oscillator pin).
- R2: `osc_fb_en_o` is 0 for the external-clock codes 4, 5, 7 and 9, and 1 for every other code.
- R3: In a code that permits no PLL (0 to 5 and 10 to 15), writes to the PLL bit are ignored. `pllen_rd_o` stays 0, `pll_en_o` stays 0 and `sys_sel_o` stays 0 (primary oscillator direct). The bit is also cleared whenever the code does not select the software policy.
- R4: In the software-policy codes 8 and 9, the PLL bit is 0 after power-on reset and after `sw_rst_i`, and `sys_sel_o` returns to 0. A write of 1 engages the PLL and moves `sys_sel_o` to 1.
- R5: After a rising edge of `pll_en_o`, `core_run_o` is 0. When the write lands on a running core with `pll_rdy_i` high, `core_run_o` returns to 1 exactly LOCK_CYCLES+2 clock edges after the edge that registers the write, with `sys_sel_o` at 1.
- R6: In the configuration-policy codes 6 and 7, the PLL engages after power-on reset with no software action. Writes to the PLL bit are ignored and read back as 0.
- R7: Under the configuration policy, a change of `mode_i` does not alter the engaged or disengaged PLL state until the clock source has gone to the secondary oscillator and come back.
- R8: While `sec_req_i` is 1, `sys_sel_o` becomes 2 and `pll_en_o` becomes 0. When the request drops, the configuration policy is re-evaluated from the current `mode_i`.
- R9: A `wake_i` or `sw_rst_i` pulse on a running core holds `core_run_o` at 0 from the next edge. When the select does not change, `core_run_o` returns to 1 after exactly LOCK_CYCLES edges.
- R10: A switch onto the PLL clock is not committed while `pll_rdy_i` is 0. The core stays halted and `sys_sel_o` holds its old value until the input rises.
- R11: Whenever `sys_sel_o` is 1, `pll_en_o` is 1. A change of `sys_sel_o` happens only at an edge before which `core_run_o` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| mode_i | input | 4 | Static oscillator-mode code |
| pllen_we_i | input | 1 | Write strobe for the software PLL bit |
| pllen_wd_i | input | 1 | Write data for the software PLL bit |
| sec_req_i | input | 1 | 1 requests the secondary oscillator, 0 the main one |
| sw_rst_i | input | 1 | Non-power-on reset event, one cycle |
| wake_i | input | 1 | Wake-up event, one cycle |
| pll_rdy_i | input | 1 | Ready indication from the analog PLL |
| pll_en_o | output | 1 | Enable of the analog PLL |
| sys_sel_o | output | 2 | System clock select: 0 primary, 1 PLL, 2 secondary |
| pin_mux_o | output | 2 | Second pin use: 0 oscillator, 1 clock/4 out, 2 port I/O |
| osc_fb_en_o | output | 1 | Enable of the feedback device between oscillator pins |
| core_run_o | output | 1 | Core execution enable |
| pllen_rd_o | output | 1 | Read-back of the software PLL bit |

## Verification
The bench builds the block with LOCK_CYCLES set to 8 instead of the default 1024. This keeps every lock window short enough to count edge by edge. The halt after a PLL start can then be told apart exactly from the halt after a wake or soft reset, which is two edges shorter. The short window also brings the two-step configuration sequence within a few hundred cycles: a mode change, a trip to the secondary oscillator and back, and a second round trip.

// File: rtl/clk_pll_pkg.sv
package clk_pll_pkg;

  localparam int MODE_W = 4;

  // oscillator-mode codes
  localparam logic [MODE_W-1:0] M_LP      = 4'd0;
  localparam logic [MODE_W-1:0] M_XT      = 4'd1;
  localparam logic [MODE_W-1:0] M_HS      = 4'd2;
  localparam logic [MODE_W-1:0] M_RC      = 4'd3;
  localparam logic [MODE_W-1:0] M_EC      = 4'd4;
  localparam logic [MODE_W-1:0] M_ECIO    = 4'd5;
  localparam logic [MODE_W-1:0] M_HS_FIX  = 4'd6;
  localparam logic [MODE_W-1:0] M_EC_FIX  = 4'd7;
  localparam logic [MODE_W-1:0] M_HS_SW   = 4'd8;
  localparam logic [MODE_W-1:0] M_ECIO_SW = 4'd9;

  typedef enum logic [1:0] {
    SEL_PRI = 2'd0,
    SEL_PLL = 2'd1,
    SEL_SEC = 2'd2
  } sys_sel_e;

  typedef enum logic [1:0] {
    PIN_OSC    = 2'd0,
    PIN_CLKOUT = 2'd1,
    PIN_GPIO   = 2'd2
  } pin_mux_e;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_SW   = 2'd1,
    POL_CFG  = 2'd2
  } pll_pol_e;

  typedef struct packed {
    pll_pol_e pol;
    pin_mux_e pin;
    logic     fb_en;
  } mode_cfg_t;

endpackage

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
  import clk_pll_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_cfg_t         cfg_o
);

  always_comb begin
    cfg_o.pol   = POL_NONE;
    cfg_o.pin   = PIN_OSC;
    cfg_o.fb_en = 1'b1;
    unique case (mode_i)
      M_EC: begin
        cfg_o.pin   = PIN_CLKOUT;
        cfg_o.fb_en = 1'b0;
      end
      M_ECIO: begin
        cfg_o.pin   = PIN_GPIO;
        cfg_o.fb_en = 1'b0;
      end
      M_HS_FIX: begin
        cfg_o.pol = POL_CFG;
      end
      M_EC_FIX: begin
        cfg_o.pol   = POL_CFG;
        cfg_o.pin   = PIN_CLKOUT;
        cfg_o.fb_en = 1'b0;
      end
      M_HS_SW: begin
        cfg_o.pol = POL_SW;
      end
      M_ECIO_SW: begin
        cfg_o.pol   = POL_SW;
        cfg_o.pin   = PIN_GPIO;
        cfg_o.fb_en = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pll_policy.sv
module pll_policy
  import clk_pll_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pll_pol_e pol_i,
  input  logic     on_sec_i,
  input  logic     sw_rst_i,
  input  logic     we_i,
  input  logic     wd_i,
  output logic     pll_want_o,
  output logic     sw_bit_o
);

  logic sw_q;
  logic cfg_q;
  logic refresh_q;

  // software bit: cleared by every reset and outside the software policy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q <= 1'b0;
    end else if (sw_rst_i || pol_i != POL_SW) begin
      sw_q <= 1'b0;
    end else if (we_i) begin
      sw_q <= wd_i;
    end
  end

  // configuration latch: sampled once after power-on, then only on secondary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= 1'b0;
      refresh_q <= 1'b1;
    end else begin
      if (refresh_q || on_sec_i) cfg_q <= (pol_i == POL_CFG);
      refresh_q <= 1'b0;
    end
  end

  assign pll_want_o = cfg_q | sw_q;
  assign sw_bit_o   = sw_q;

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  output logic done_o
);

  if (LOCK_CYCLES == 0) begin : g_no_timer
    assign done_o = 1'b1;
  end else begin : g_timer
    localparam int TW = $clog2(LOCK_CYCLES + 1);
    localparam logic [TW-1:0] RELOAD = TW'(LOCK_CYCLES);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= RELOAD;
      end else if (reload_i) begin
        cnt_q <= RELOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end

    assign done_o = (cnt_q == '0);
  end

endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_pll_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pll_want_i,
  input  logic     sec_req_i,
  input  logic     pll_rdy_i,
  input  logic     lock_done_i,
  input  logic     hold_i,
  output sys_sel_e sel_o,
  output logic     pll_en_o,
  output logic     pll_rise_o,
  output logic     core_run_o
);

  sys_sel_e target;
  sys_sel_e sel_q;
  logic     pll_en_q;
  logic     pll_en_d;
  logic     commit;

  always_comb begin
    if (sec_req_i)       target = SEL_SEC;
    else if (pll_want_i) target = SEL_PLL;
    else                 target = SEL_PRI;
  end

  // PLL stays powered until the select has moved off it
  assign pll_en_d   = (target == SEL_PLL) || (sel_q == SEL_PLL);
  assign pll_rise_o = pll_en_d && !pll_en_q;

  assign commit = lock_done_i && !hold_i && (target != sel_q) &&
                  ((target != SEL_PLL) || pll_rdy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SEL_PRI;
      pll_en_q <= 1'b0;
    end else begin
      pll_en_q <= pll_en_d;
      if (commit) sel_q <= target;
    end
  end

  assign sel_o      = sel_q;
  assign pll_en_o   = pll_en_q;
  assign core_run_o = lock_done_i && (target == sel_q);

endmodule

// File: rtl/clk_pll_ctrl.sv
module clk_pll_ctrl
  import clk_pll_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pllen_we_i,
  input  logic              pllen_wd_i,
  input  logic              sec_req_i,
  input  logic              sw_rst_i,
  input  logic              wake_i,
  input  logic              pll_rdy_i,
  output logic              pll_en_o,
  output logic [1:0]        sys_sel_o,
  output logic [1:0]        pin_mux_o,
  output logic              osc_fb_en_o,
  output logic              core_run_o,
  output logic              pllen_rd_o
);

  mode_cfg_t mcfg;
  sys_sel_e  sel;
  logic      pll_want;
  logic      pll_rise;
  logic      lock_done;
  logic      reload;

  clk_mode_decode u_decode (
    .mode_i (mode_i),
    .cfg_o  (mcfg)
  );

  pll_policy u_policy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pol_i      (mcfg.pol),
    .on_sec_i   (sel == SEL_SEC),
    .sw_rst_i   (sw_rst_i),
    .we_i       (pllen_we_i),
    .wd_i       (pllen_wd_i),
    .pll_want_o (pll_want),
    .sw_bit_o   (pllen_rd_o)
  );

  assign reload = pll_rise | sw_rst_i | wake_i;

  pll_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .done_o   (lock_done)
  );

  clk_sel_ctrl u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pll_want_i  (pll_want),
    .sec_req_i   (sec_req_i),
    .pll_rdy_i   (pll_rdy_i),
    .lock_done_i (lock_done),
    .hold_i      (reload),
    .sel_o       (sel),
    .pll_en_o    (pll_en_o),
    .pll_rise_o  (pll_rise),
    .core_run_o  (core_run_o)
  );

  assign sys_sel_o   = sel;
  assign pin_mux_o   = mcfg.pin;
  assign osc_fb_en_o = mcfg.fb_en;

endmodule

// File: rtl/clk_pll_ctrl_chk.sv
module clk_pll_ctrl_chk #(
  parameter int unsigned LOCK_CYCLES = 1024
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] mode_i,
  input logic       sw_rst_i,
  input logic       wake_i,
  input logic       pll_en_o,
  input logic [1:0] sys_sel_o,
  input logic       core_run_o,
  input logic       pllen_rd_o
);

  a_r11_pll_sel_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_sel_o == 2'd1) |-> pll_en_o);

  a_r11_switch_while_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sys_sel_o) |-> $past(!core_run_o));

  a_r5_halt_on_pll_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> !core_run_o);

  a_r3_bit_only_in_sw_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pllen_rd_o |-> $past(mode_i == 4'd8 || mode_i == 4'd9));

  a_r4_soft_reset_clears_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !pllen_rd_o);

  if (LOCK_CYCLES > 0) begin : g_hold
    a_r9_event_halts_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_i || sw_rst_i) |=> !core_run_o);
  end

endmodule

bind clk_pll_ctrl clk_pll_ctrl_chk #(
  .LOCK_CYCLES (LOCK_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .sw_rst_i   (sw_rst_i),
  .wake_i     (wake_i),
  .pll_en_o   (pll_en_o),
  .sys_sel_o  (sys_sel_o),
  .core_run_o (core_run_o),
  .pllen_rd_o (pllen_rd_o)
);

// File: tb/clk_pll_ctrl_test.sv
`timescale 1ns/1ps
module clk_pll_ctrl_test;

  localparam int L = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] mode_i = 4'd0;
  logic       pllen_we_i = 1'b0;
  logic       pllen_wd_i = 1'b0;
  logic       sec_req_i = 1'b0;
  logic       sw_rst_i = 1'b0;
  logic       wake_i = 1'b0;
  logic       pll_rdy_i = 1'b1;
  logic       pll_en_o;
  logic [1:0] sys_sel_o;
  logic [1:0] pin_mux_o;
  logic       osc_fb_en_o;
  logic       core_run_o;
  logic       pllen_rd_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  clk_pll_ctrl #(.LOCK_CYCLES(L)) uut (
    .clk_i, .rst_ni, .mode_i, .pllen_we_i, .pllen_wd_i, .sec_req_i,
    .sw_rst_i, .wake_i, .pll_rdy_i, .pll_en_o, .sys_sel_o, .pin_mux_o,
    .osc_fb_en_o, .core_run_o, .pllen_rd_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic por(input logic [3:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_i = m;
    pllen_we_i = 1'b0;
    sec_req_i = 1'b0;
    sw_rst_i = 1'b0;
    wake_i = 1'b0;
    cycles(2);
    rst_ni = 1'b1;
  endtask

  task automatic write_bit(input logic v);
    @(negedge clk_i);
    pllen_we_i = 1'b1;
    pllen_wd_i = v;
    @(negedge clk_i);
    pllen_we_i = 1'b0;
  endtask

  task automatic count_to_run(output int n);
    n = 0;
    while (!core_run_o && n < 1000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic t_reset_state();
    por(4'd8);
    #1;
    check("reset core_run", core_run_o, 0);
    check("reset sys_sel", sys_sel_o, 0);
    check("reset pll_en", pll_en_o, 0);
    check("R4 reset bit", pllen_rd_o, 0);
  endtask

  task automatic t_pin_decode();
    for (int m = 0; m < 16; m++) begin
      int ep;
      int ef;
      ep = (m == 4 || m == 7) ? 1 : (m == 5 || m == 9) ? 2 : 0;
      ef = (m == 4 || m == 5 || m == 7 || m == 9) ? 0 : 1;
      @(negedge clk_i);
      mode_i = 4'(m);
      #1;
      check($sformatf("R1 pin mode %0d", m), pin_mux_o, ep);
      check($sformatf("R2 fb mode %0d", m), osc_fb_en_o, ef);
    end
  endtask

  task automatic t_plain_mode();
    por(4'd2);
    cycles(3 * L);
    write_bit(1'b1);
    cycles(3 * L);
    check("R3 bit readback", pllen_rd_o, 0);
    check("R3 pll_en", pll_en_o, 0);
    check("R3 sys_sel", sys_sel_o, 0);
    check("R3 core_run", core_run_o, 1);
  endtask

  task automatic t_sw_policy();
    int n;
    por(4'd8);
    cycles(3 * L);
    check("R4 idle sel", sys_sel_o, 0);
    check("R4 idle run", core_run_o, 1);
    write_bit(1'b1);
    check("R5 halt after write", core_run_o, 0);
    count_to_run(n);
    check("R5 lock edges", n, L + 2);
    check("R4 sel pll", sys_sel_o, 1);
    check("R11 pll_en with pll sel", pll_en_o, 1);
    check("R4 bit readback", pllen_rd_o, 1);
    @(negedge clk_i);
    sw_rst_i = 1'b1;
    @(negedge clk_i);
    sw_rst_i = 1'b0;
    check("R4 soft reset bit", pllen_rd_o, 0);
    check("R9 soft reset halt", core_run_o, 0);
    cycles(3 * L);
    check("R4 soft reset sel", sys_sel_o, 0);
    check("R4 soft reset pll_en", pll_en_o, 0);
    check("R4 soft reset run", core_run_o, 1);
  endtask

  task automatic t_cfg_policy();
    por(4'd6);
    cycles(3 * L + 4);
    check("R6 cfg sel pll", sys_sel_o, 1);
    check("R6 cfg pll_en", pll_en_o, 1);
    check("R6 cfg run", core_run_o, 1);
    write_bit(1'b0);
    write_bit(1'b1);
    cycles(2);
    check("R6 write ignored", pllen_rd_o, 0);
    check("R6 still pll", sys_sel_o, 1);
    @(negedge clk_i);
    mode_i = 4'd2;
    cycles(3 * L);
    check("R7 no on-the-fly off", sys_sel_o, 1);
    check("R7 pll_en kept", pll_en_o, 1);
    @(negedge clk_i);
    sec_req_i = 1'b1;
    cycles(3 * L);
    check("R8 sel secondary", sys_sel_o, 2);
    check("R8 pll off on secondary", pll_en_o, 0);
    @(negedge clk_i);
    sec_req_i = 1'b0;
    cycles(3 * L);
    check("R8 reevaluated off", sys_sel_o, 0);
    check("R8 pll_en off", pll_en_o, 0);
    @(negedge clk_i);
    mode_i = 4'd6;
    cycles(3 * L);
    check("R7 no on-the-fly on", sys_sel_o, 0);
    @(negedge clk_i);
    sec_req_i = 1'b1;
    cycles(3 * L);
    @(negedge clk_i);
    sec_req_i = 1'b0;
    cycles(3 * L + 4);
    check("R8 reevaluated on", sys_sel_o, 1);
    check("R8 run on pll", core_run_o, 1);
  endtask

  task automatic t_wake();
    int n;
    por(4'd9);
    cycles(3 * L);
    write_bit(1'b1);
    cycles(3 * L);
    check("R9 pre wake run", core_run_o, 1);
    @(negedge clk_i);
    wake_i = 1'b1;
    @(negedge clk_i);
    wake_i = 1'b0;
    check("R9 wake halt", core_run_o, 0);
    count_to_run(n);
    check("R9 wake edges", n, L);
    check("R9 sel kept", sys_sel_o, 1);
    por(4'd2);
    cycles(3 * L);
    @(negedge clk_i);
    sw_rst_i = 1'b1;
    @(negedge clk_i);
    sw_rst_i = 1'b0;
    count_to_run(n);
    check("R9 soft reset edges", n, L);
  endtask

  task automatic t_ready();
    pll_rdy_i = 1'b0;
    por(4'd9);
    cycles(3 * L);
    write_bit(1'b1);
    cycles(4 * L);
    check("R10 held sel", sys_sel_o, 0);
    check("R10 held run", core_run_o, 0);
    check("R10 pll powered", pll_en_o, 1);
    @(negedge clk_i);
    pll_rdy_i = 1'b1;
    cycles(2);
    check("R10 sel after ready", sys_sel_o, 1);
    check("R10 run after ready", core_run_o, 1);
  endtask

  initial begin
    t_reset_state();
    t_pin_decode();
    t_plain_mode();
    t_sw_policy();
    t_cfg_policy();
    t_wake();
    t_ready();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule